// File: doc/BRIEF.md
# Mobile SDRAM Command Encoder

This block turns abstract memory requests into pin-level commands for a four-bank, x16 low-power SDRAM. A requester presents one operation per clock: row open, column read or write, single-bank or all-bank close, auto refresh, self-refresh entry, burst stop, deep power-down entry, mode register load, NOP or chip deselect. The block drives registered chip select, the three strobes, clock enable, bank and address pins.

Two operation pairs share one strobe encoding each: refresh and self-refresh entry, and burst stop and deep power-down entry. The clock-enable level tells the memory which one is meant. Once a power-down entry has been issued, clock enable stays low through idle, NOP and deselect cycles. The next request of any other kind raises it in the same cycle as that request's pins.

A separate per-byte mask input is aligned to the data beats. Write masks reach the DQM pins one cycle after they are presented. Read masks reach them `CAS_LAT-1` cycles after they are presented, so that they lead the returning read data by two cycles.

The request side uses valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low only during reset, so the requester must hold its request until then and never sees back-pressure later. The mask inputs are plain control pins with no handshake.

Top module: `lpsdr_cmd_enc`

## Requirements
- R1: While reset is asserted, `req_ready` is low, the pins show NOP, clock enable is high and both DQM pins are low. In the first cycle after reset is released, `req_ready` is high.
- R2: A request accepted at a rising edge appears on the pins after that edge. The `req_op` codes map to CS#,RAS#,CAS#,WE# as follows:
  - 0 NOP: LHHH
  - 1 deselect: CS# high, the strobes high
  - 2 activate: LLHH
  - 3 read: LHLH
  - 4 write: LHLL
  - 5 precharge one bank: LLHL
  - 6 precharge all banks: LLHL
  - 7 auto refresh: LLLH
  - 8 self-refresh entry: LLLH
  - 9 burst stop: LHHL
  - 10 deep power-down entry: LHHL
  - 11 mode load: LLLL
  - codes 12 to 15: NOP
- R3: Activate drives `req_addr` (the row) on A[11:0] and `req_bank` on BA.
- R4: Read and write drive `req_addr[8:0]` (the column) on A[8:0], `req_ap` (auto precharge) on A10, zero on A9 and A11, and `req_bank` on BA.
- R5: Precharge of one bank drives A10 low and `req_bank` on BA. Precharge of all banks drives A10 high and BA zero. All other address bits are zero in both cases.
- R6: Mode load drives `req_addr` on A[11:0] and `req_bank` on BA.
- R7: NOP, deselect, refresh, self-refresh, burst stop, deep power-down and the undefined codes drive A and BA to zero.
- R8: Clock enable goes low with self-refresh entry and deep power-down entry. It is high with auto refresh and burst stop.
- R9: After a power-down entry, clock enable stays low through idle cycles, NOP and deselect requests. Any other request drives it high together with that request's pins.
- R10: The pins show NOP, with A and BA at zero, in the cycle after every rising edge at which no request is accepted.
- R11: A mask presented with `dm_valid` appears on the DQM pins once only: bit 0 on DQML (DQ0–7) and bit 1 on DQMH (DQ8–15). It appears after 1 edge for a write (`dm_read`=0) and after `CAS_LAT-1` edges for a read (`dm_read`=1). Otherwise the DQM pins are low.
- R12: A read mask and a write mask that land in the same cycle are combined bitwise OR on the DQM pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 4 | Operation code (R2) |
| req_bank | input | 2 | Bank select |
| req_addr | input | 12 | Row, column or mode word |
| req_ap | input | 1 | Auto precharge for read and write |
| dm_valid | input | 1 | Mask request present |
| dm_read | input | 1 | Mask belongs to a read beat |
| dm_bytes | input | 2 | Per-byte mask, bit 1 upper byte |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Address |
| sd_dqml | output | 1 | Lower byte mask |
| sd_dqmh | output | 1 | Upper byte mask |

## Verification
Command and clock-enable results are due one rising edge after acceptance. The bench drives at a falling edge and samples at the next falling edge. The bench checks write masks one edge after they are presented and read masks `CAS_LAT-1` edges after. It also samples the neighbouring cycles, where DQM must be low. The bench's reference model for clock enable lags by the same single edge, so its long sequences of power-down entry, idle and wake are compared cycle by cycle.

// File: rtl/lpsdr_pkg.sv
package lpsdr_pkg;

  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;
  localparam int BANK_W = 2;
  localparam int AP_BIT = 10;
  localparam int DQM_W  = 2;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_DESEL   = 4'd1,
    OP_ACT     = 4'd2,
    OP_RD      = 4'd3,
    OP_WR      = 4'd4,
    OP_PRE     = 4'd5,
    OP_PREALL  = 4'd6,
    OP_AREF    = 4'd7,
    OP_SREF    = 4'd8,
    OP_BST     = 4'd9,
    OP_DPD     = 4'd10,
    OP_MODE    = 4'd11
  } req_op_e;

  typedef struct packed {
    logic              cs_n;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0]  a;
  } pin_bus_t;

  localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                    we_n: 1'b1, ba: '0, a: '0};

endpackage

// File: rtl/lpsdr_cmd_map.sv
module lpsdr_cmd_map
  import lpsdr_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  addr,
  input  logic              ap,
  output pin_bus_t          pins,
  output logic              pd_entry,
  output logic              wake
);

  always_comb begin
    pins     = PIN_IDLE;
    pd_entry = 1'b0;
    wake     = 1'b1;
    case (op)
      OP_NOP: wake = 1'b0;
      OP_DESEL: begin
        pins.cs_n = 1'b1;
        wake      = 1'b0;
      end
      OP_ACT: begin
        pins.ras_n = 1'b0;
        pins.ba    = bank;
        pins.a     = addr;
      end
      OP_RD: begin
        pins.cas_n            = 1'b0;
        pins.ba               = bank;
        pins.a[COL_W-1:0]     = addr[COL_W-1:0];
        pins.a[AP_BIT]        = ap;
      end
      OP_WR: begin
        pins.cas_n            = 1'b0;
        pins.we_n             = 1'b0;
        pins.ba               = bank;
        pins.a[COL_W-1:0]     = addr[COL_W-1:0];
        pins.a[AP_BIT]        = ap;
      end
      OP_PRE: begin
        pins.ras_n = 1'b0;
        pins.we_n  = 1'b0;
        pins.ba    = bank;
      end
      OP_PREALL: begin
        pins.ras_n     = 1'b0;
        pins.we_n      = 1'b0;
        pins.a[AP_BIT] = 1'b1;
      end
      OP_AREF: begin
        pins.ras_n = 1'b0;
        pins.cas_n = 1'b0;
      end
      OP_SREF: begin
        pins.ras_n = 1'b0;
        pins.cas_n = 1'b0;
        pd_entry   = 1'b1;
        wake       = 1'b0;
      end
      OP_BST: pins.we_n = 1'b0;
      OP_DPD: begin
        pins.we_n = 1'b0;
        pd_entry  = 1'b1;
        wake      = 1'b0;
      end
      OP_MODE: begin
        pins.ras_n = 1'b0;
        pins.cas_n = 1'b0;
        pins.we_n  = 1'b0;
        pins.ba    = bank;
        pins.a     = addr;
      end
      default: wake = 1'b0;
    endcase
  end

  // R4
  always_comb begin
    if (!pins.cs_n && pins.ras_n && !pins.cas_n)
      col_upper_zero_chk: assert (pins.a[ROW_W-1] == 1'b0 && pins.a[COL_W] == 1'b0);
  end

endmodule

// File: rtl/lpsdr_cke_ctl.sv
module lpsdr_cke_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic pd_entry,
  input  logic wake,
  output logic cke
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cke <= 1'b1;
    else if (accept && pd_entry) cke <= 1'b0;
    else if (accept && wake)     cke <= 1'b1;
  end

  // R8
  entry_drops_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pd_entry) |=> !cke);

  // R9
  cke_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(accept && wake));

  // R9
  cke_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(accept && pd_entry));

endmodule

// File: rtl/lpsdr_dqm_align.sv
module lpsdr_dqm_align
  import lpsdr_pkg::*;
#(
  parameter int CAS_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dm_valid,
  input  logic             dm_read,
  input  logic [DQM_W-1:0] dm_bytes,
  output logic [DQM_W-1:0] dqm
);

  localparam int RD_EXTRA = CAS_LAT - 2;

  logic [DQM_W-1:0] wr_now, rd_now, rd_tap;

  assign wr_now = (dm_valid && !dm_read) ? dm_bytes : '0;
  assign rd_now = (dm_valid &&  dm_read) ? dm_bytes : '0;

  generate
    if (RD_EXTRA <= 0) begin : g_rd_direct
      assign rd_tap = rd_now;
    end else begin : g_rd_pipe
      logic [DQM_W-1:0] stage [RD_EXTRA];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < RD_EXTRA; i++) stage[i] <= '0;
        end else begin
          stage[0] <= rd_now;
          for (int i = 1; i < RD_EXTRA; i++) stage[i] <= stage[i-1];
        end
      end
      assign rd_tap = stage[RD_EXTRA-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dqm <= '0;
    else        dqm <= wr_now | rd_tap;
  end

  // R11
  write_mask_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && !dm_read) |=> ((dqm & $past(dm_bytes)) == $past(dm_bytes)));

endmodule

// File: rtl/lpsdr_cmd_enc.sv
module lpsdr_cmd_enc
  import lpsdr_pkg::*;
#(
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_addr,
  input  logic              req_ap,
  input  logic              dm_valid,
  input  logic              dm_read,
  input  logic [DQM_W-1:0]  dm_bytes,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic              sd_dqml,
  output logic              sd_dqmh
);

  logic             rdy_q;
  logic             accept;
  pin_bus_t         map_pins, pins_q;
  logic             pd_entry, wake;
  logic [DQM_W-1:0] dqm;

  assign accept    = req_valid && rdy_q;
  assign req_ready = rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  lpsdr_cmd_map u_map (
    .op       (req_op),
    .bank     (req_bank),
    .addr     (req_addr),
    .ap       (req_ap),
    .pins     (map_pins),
    .pd_entry (pd_entry),
    .wake     (wake)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pins_q <= PIN_IDLE;
    else if (accept) pins_q <= map_pins;
    else             pins_q <= PIN_IDLE;
  end

  lpsdr_cke_ctl u_cke (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .pd_entry (pd_entry),
    .wake     (wake),
    .cke      (sd_cke)
  );

  lpsdr_dqm_align #(.CAS_LAT(CAS_LAT)) u_dqm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dm_valid (dm_valid),
    .dm_read  (dm_read),
    .dm_bytes (dm_bytes),
    .dqm      (dqm)
  );

  assign sd_cs_n  = pins_q.cs_n;
  assign sd_ras_n = pins_q.ras_n;
  assign sd_cas_n = pins_q.cas_n;
  assign sd_we_n  = pins_q.we_n;
  assign sd_ba    = pins_q.ba;
  assign sd_a     = pins_q.a;
  assign sd_dqml  = dqm[0];
  assign sd_dqmh  = dqm[1];

  // R10
  idle_gives_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=>
      (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && sd_a == '0 && sd_ba == '0));

  // R5
  preall_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n && sd_a[AP_BIT]) |-> sd_ba == '0);

endmodule

// File: tb/lpsdr_cmd_enc_tb_top.sv
module lpsdr_cmd_enc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_addr = '0;
  logic        req_ap = 1'b0;
  logic        dm_valid = 1'b0;
  logic        dm_read = 1'b0;
  logic [1:0]  dm_bytes = '0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqml, sd_dqmh;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  int checks = 0;
  int errs = 0;
  logic model_cke = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpsdr_cmd_enc #(.CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr), .req_ap(req_ap),
    .dm_valid(dm_valid), .dm_read(dm_read), .dm_bytes(dm_bytes),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqml(sd_dqml), .sd_dqmh(sd_dqmh)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_strobes(input int op);
    case (op)
      1: return 4'b1111;
      2: return 4'b0011;
      3: return 4'b0101;
      4: return 4'b0100;
      5, 6: return 4'b0010;
      7, 8: return 4'b0001;
      9, 10: return 4'b0110;
      11: return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic logic [13:0] exp_bank_addr(input int op, input logic [1:0] b,
                                                input logic [11:0] ad, input logic ap);
    case (op)
      2, 11: return {b, ad};
      3, 4:  return {b, 1'b0, ap, 1'b0, ad[8:0]};
      5:     return {b, 12'h000};
      6:     return {2'b00, 12'h400};
      default: return 14'h0;
    endcase
  endfunction

  function automatic string addr_tag(input int op);
    case (op)
      2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send(input int op, input logic [1:0] b, input logic [11:0] ad, input logic ap);
    req_valid = 1'b1;
    req_op = op[3:0];
    req_bank = b;
    req_addr = ad;
    req_ap = ap;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 8 || op == 10) model_cke = 1'b0;
    else if (op >= 2 && op <= 11) model_cke = 1'b1;
    chk("R2", "strobes", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_strobes(op));
    chk(addr_tag(op), "bank/addr", {sd_ba, sd_a}, exp_bank_addr(op, b, ad, ap));
    if (op == 7 || op == 8 || op == 9 || op == 10)
      chk("R8", "cke", sd_cke, model_cke);
    else
      chk("R9", "cke", sd_cke, model_cke);
  endtask

  task automatic idle_check();
    @(posedge clk);
    @(negedge clk);
    chk("R10", "idle pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a}, {4'b0111, 14'h0});
    chk("R9", "idle cke", sd_cke, model_cke);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [11:0] pats [4];
    pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hA5A; pats[3] = 12'h5A5;

    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", req_ready, 1'b0);
    chk("R1", "pins in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a}, {4'b0111, 14'h0});
    chk("R1", "cke in reset", sd_cke, 1'b1);
    chk("R1", "dqm in reset", {sd_dqmh, sd_dqml}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1'b1);

    for (int op = 0; op < 16; op++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 4; p++)
          for (int ap = 0; ap < 2; ap++) begin
            send(op, b[1:0], pats[p], ap[0]);
            if (((b + p + ap) % 3) == 0) idle_check();
          end

    // R9: hold low through idle, NOP and deselect, wake on refresh
    send(8, 2'd0, 12'h0, 1'b0);
    idle_check();
    idle_check();
    send(0, 2'd0, 12'h0, 1'b0);
    send(1, 2'd0, 12'h0, 1'b0);
    send(13, 2'd0, 12'h0, 1'b0);
    chk("R9", "cke held", sd_cke, 1'b0);
    send(7, 2'd0, 12'h0, 1'b0);
    chk("R9", "cke woke", sd_cke, 1'b1);
    send(10, 2'd0, 12'h0, 1'b0);
    idle_check();
    send(2, 2'd3, 12'h123, 1'b0);
    chk("R9", "cke woke by act", sd_cke, 1'b1);

    // R11: mask latency sweep
    for (int rd = 0; rd < 2; rd++)
      for (int m = 0; m < 4; m++) begin
        dm_valid = 1'b1;
        dm_read = rd[0];
        dm_bytes = m[1:0];
        for (int k = 1; k <= 3; k++) begin
          @(posedge clk);
          @(negedge clk);
          dm_valid = 1'b0;
          if ((rd == 0 && k == 1) || (rd == 1 && k == CL - 1))
            chk("R11", "dqm due", {sd_dqmh, sd_dqml}, m[1:0]);
          else
            chk("R11", "dqm quiet", {sd_dqmh, sd_dqml}, 2'b00);
        end
      end

    // R12: read mask and later write mask meet in one cycle
    dm_valid = 1'b1; dm_read = 1'b1; dm_bytes = 2'b01;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "before merge", {sd_dqmh, sd_dqml}, 2'b00);
    dm_read = 1'b0; dm_bytes = 2'b10;
    @(posedge clk);
    @(negedge clk);
    dm_valid = 1'b0;
    chk("R12", "merged", {sd_dqmh, sd_dqml}, 2'b11);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "after merge", {sd_dqmh, sd_dqml}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule